// File: doc/BRIEF.md
# UART FIFO Interrupt Request Generator

This block sits next to the transmit and receive FIFOs of a UART. It turns their occupancy counts, the clear-to-send pin and the receiver's stale-data flag into one interrupt request line. Six fill-level conditions are decoded from the two occupancy counts. A seventh condition records any change on the clear-to-send pin, and an eighth passes the receiver's old-data flag through. An enable vector from a control register selects which conditions can raise the request.

The clear-to-send pin is asynchronous, so it passes through two synchronizer flops before edge detection. A detected change sets a sticky delta flag. That flag stays set until a one-cycle clear pulse arrives. If a new change is detected in the same cycle as the clear, the flag stays set. The raw conditions and the synchronized pin level are shown on a status vector so the owner of the interrupt can read which source fired. The FIFO depth is a parameter. The occupancy inputs are just wide enough to encode 0 through the depth.

Top module: `uart_irq_gen`

## Requirements
- R1: `status[0]` (receive ready) is 1 exactly when `rx_count` is at least 1.
- R2: `status[1]` (receive half) is 1 exactly when `2*rx_count` is strictly greater than `DEPTH`.
- R3: `status[2]` (receive full) is 1 exactly when `rx_count` equals `DEPTH`.
- R4: `status[3]` (transmit empty) is 1 exactly when `tx_count` is 0.
- R5: `status[4]` (transmit half) is 1 exactly when `2*tx_count` is strictly less than `DEPTH`.
- R6: `status[5]` (transmit slot free) is 1 exactly when `tx_count` is less than `DEPTH`.
- R7: `status[8]` shows the synchronized `cts_pin` level two rising edges after the pin changes. `status[6]` (CTS delta) becomes 1 on the third rising edge after either a rising or a falling change of the pin.
- R8: Once set, `status[6]` holds until `delta_clr` is 1 at a rising edge. A clear with no new change drops it at that edge.
- R9: If a pin change is detected at the same edge where `delta_clr` is 1, `status[6]` stays 1.
- R10: `status[7]` (old data) equals the `old_data` input.
- R11: `irq` is registered. At each rising edge it takes the OR over i=0..7 of `enable[i] & status[i]`, so an enable bit of 0 masks its condition.
- R12: While `rst_n` is 0, `irq`, `status[6]` and the synchronizer flops are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_count | input | CNT_W | Receive FIFO occupancy, 0..DEPTH |
| tx_count | input | CNT_W | Transmit FIFO occupancy, 0..DEPTH |
| cts_pin | input | 1 | Asynchronous clear-to-send pin |
| old_data | input | 1 | Receiver old-data flag |
| enable | input | 8 | Per-condition enables, bit i gates status bit i |
| delta_clr | input | 1 | Write-one-to-clear pulse for the CTS delta flag |
| irq | output | 1 | Registered interrupt request |
| status | output | 9 | Raw conditions [7:0], synchronized CTS level [8] |

## Verification
The threshold decoders are exercised with counts one step either side of each limit: half depth exactly, depth minus one, zero and full. An off-by-one compare at any of these points flips a status bit, and the check reports it. The CTS path is timed edge by edge for both directions of change. A synchronizer with the wrong number of stages, or an edge detector that sees only rising edges, sets the delta flag in the wrong cycle or not at all. A clear that coincides with a fresh edge catches a design that lets the clear win. Random enable masks against random fill patterns catch a source wired to the wrong enable bit, and an output that is not registered.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NUM_SRC     = 8;
    localparam int SRC_RX_RDY  = 0;
    localparam int SRC_RX_HALF = 1;
    localparam int SRC_RX_FULL = 2;
    localparam int SRC_TX_EMPT = 3;
    localparam int SRC_TX_HALF = 4;
    localparam int SRC_TX_FREE = 5;
    localparam int SRC_CTS_DLT = 6;
    localparam int SRC_OLD     = 7;
    localparam int STAT_W      = NUM_SRC + 1;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } cts_sync_t;

    typedef struct packed {
        logic delta;
        logic irq;
    } irq_state_t;
endpackage

// File: rtl/uart_irq_levels.sv
module uart_irq_levels #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    output logic [5:0]       level_cond
);
    import uart_irq_pkg::*;

    localparam logic [CNT_W:0] DEPTH_W = (CNT_W + 1)'(DEPTH);

    logic [CNT_W:0] rx_dbl;
    logic [CNT_W:0] tx_dbl;
    logic [CNT_W:0] rx_ext;
    logic [CNT_W:0] tx_ext;

    always_comb begin
        rx_ext = {1'b0, rx_count};
        tx_ext = {1'b0, tx_count};
        rx_dbl = {rx_count, 1'b0};
        tx_dbl = {tx_count, 1'b0};
        level_cond                 = '0;
        level_cond[SRC_RX_RDY]     = (rx_ext != '0);
        level_cond[SRC_RX_HALF]    = (rx_dbl > DEPTH_W);
        level_cond[SRC_RX_FULL]    = (rx_ext == DEPTH_W);
        level_cond[SRC_TX_EMPT]    = (tx_ext == '0);
        level_cond[SRC_TX_HALF]    = (tx_dbl < DEPTH_W);
        level_cond[SRC_TX_FREE]    = (tx_ext < DEPTH_W);
    end
endmodule

// File: rtl/uart_irq_cts_sync.sv
module uart_irq_cts_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic changed
);
    import uart_irq_pkg::*;

    cts_sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pin;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level   = sync_q.s2;
    assign changed = sync_q.s2 ^ sync_q.s3;
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             cts_pin,
    input  logic             old_data,
    input  logic [7:0]       enable,
    input  logic             delta_clr,
    output logic             irq,
    output logic [8:0]       status
);
    import uart_irq_pkg::*;

    logic [5:0]         level_cond;
    logic               cts_level;
    logic               cts_changed;
    logic [NUM_SRC-1:0] cond;
    irq_state_t         st_d, st_q;

    uart_irq_levels #(.DEPTH(DEPTH)) u_levels (
        .rx_count   (rx_count),
        .tx_count   (tx_count),
        .level_cond (level_cond)
    );

    uart_irq_cts_sync u_cts (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (cts_pin),
        .level   (cts_level),
        .changed (cts_changed)
    );

    always_comb begin
        cond              = {2'b00, level_cond};
        cond[SRC_CTS_DLT] = st_q.delta;
        cond[SRC_OLD]     = old_data;

        st_d       = st_q;
        st_d.delta = (st_q.delta & ~delta_clr) | cts_changed;
        st_d.irq   = |(cond & enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq    = st_q.irq;
    assign status = {cts_level, cond};
endmodule

// File: rtl/uart_irq_gen_chk.sv
module uart_irq_gen_chk #(
    parameter int DEPTH = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] enable,
    input logic       delta_clr,
    input logic       irq,
    input logic [8:0] status
);
    // R3 / R2: a full receive FIFO is always more than half full
    a_r3_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> status[1]);

    // R4 / R5: an empty transmit FIFO is always below half
    a_r4_empty_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] |-> status[4]);

    // R7: a change of the synchronized level sets the delta flag next edge
    a_r7_change_sets_delta: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[8]) |=> status[6]);

    // R8: the delta flag holds while no clear arrives
    a_r8_delta_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && !delta_clr) |=> status[6]);

    // R11: irq is the registered OR of the enabled conditions
    a_r11_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == $past(|(enable & status[7:0]))));
endmodule

bind uart_irq_gen uart_irq_gen_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .delta_clr (delta_clr),
    .irq       (irq),
    .status    (status)
);

// File: tb/tb_uart_irq_gen.sv
module tb_uart_irq_gen;
    localparam int DEPTH    = 8;
    localparam int CNT_W    = $clog2(DEPTH + 1);
    localparam int CLK_PER  = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] rx_count;
    logic [CNT_W-1:0] tx_count;
    logic             cts_pin;
    logic             old_data;
    logic [7:0]       enable;
    logic             delta_clr;
    logic             irq;
    logic [8:0]       status;

    int n_chk  = 0;
    int n_fail = 0;

    uart_irq_gen #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .cts_pin(cts_pin), .old_data(old_data), .enable(enable),
        .delta_clr(delta_clr), .irq(irq), .status(status)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic logic [5:0] exp_levels(int rx, int tx);
        logic [5:0] e;
        e[0] = rx >= 1;
        e[1] = 2*rx > DEPTH;
        e[2] = rx == DEPTH;
        e[3] = tx == 0;
        e[4] = 2*tx < DEPTH;
        e[5] = tx < DEPTH;
        return e;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic levels_check(int rx, int tx);
        logic [5:0] e;
        @(negedge clk);
        rx_count = CNT_W'(rx);
        tx_count = CNT_W'(tx);
        #1;
        e = exp_levels(rx, tx);
        check("R1", 32'(status[0]), 32'(e[0]));
        check("R2", 32'(status[1]), 32'(e[1]));
        check("R3", 32'(status[2]), 32'(e[2]));
        check("R4", 32'(status[3]), 32'(e[3]));
        check("R5", 32'(status[4]), 32'(e[4]));
        check("R6", 32'(status[5]), 32'(e[5]));
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] exp_c;
        logic       exp_irq;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; rx_count = '0; tx_count = '0; cts_pin = 1'b1;
        old_data = 1'b1; enable = 8'hFF; delta_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset holds irq, delta and synchronizer low
        check("R12 irq", 32'(irq), 0);
        check("R12 delta", 32'(status[6]), 0);
        check("R12 sync", 32'(status[8]), 0);
        cts_pin = 1'b0; old_data = 1'b0; enable = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Directed threshold corners: R1..R6
        levels_check(0, 0);
        levels_check(1, DEPTH - 1);
        levels_check(DEPTH/2, DEPTH/2);
        levels_check(DEPTH/2 + 1, DEPTH/2 - 1);
        levels_check(DEPTH, DEPTH);
        levels_check(DEPTH - 1, 1);

        // R7: rising change, exact timing
        @(negedge clk); rx_count = '0; tx_count = CNT_W'(DEPTH); cts_pin = 1'b1;
        @(negedge clk);
        check("R7 level early", 32'(status[8]), 0);
        @(negedge clk);
        check("R7 level", 32'(status[8]), 1);
        check("R7 delta early", 32'(status[6]), 0);
        @(negedge clk);
        check("R7 delta rise", 32'(status[6]), 1);
        // R8: sticky across idle cycles, irq masked while enable is 0
        repeat (3) @(negedge clk);
        check("R8 sticky", 32'(status[6]), 1);
        check("R11 masked", 32'(irq), 0);
        enable = 8'h40;
        @(negedge clk);
        check("R11 delta irq", 32'(irq), 1);
        // R8: clear alone
        delta_clr = 1'b1;
        @(negedge clk);
        delta_clr = 1'b0;
        check("R8 clear", 32'(status[6]), 0);
        @(negedge clk);
        check("R11 irq drop", 32'(irq), 0);

        // R7: falling change, then R9 coincidence with clear
        cts_pin = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 delta fall", 32'(status[6]), 1);
        cts_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        delta_clr = 1'b1;
        @(negedge clk);
        delta_clr = 1'b0;
        check("R9 edge wins", 32'(status[6]), 1);
        delta_clr = 1'b1;
        @(negedge clk);
        delta_clr = 1'b0;
        check("R9 later clear", 32'(status[6]), 0);

        // R10: old data mirror and gating
        enable = 8'h80; old_data = 1'b1; #1;
        check("R10 old", 32'(status[7]), 1);
        @(negedge clk);
        check("R11 old irq", 32'(irq), 1);
        old_data = 1'b0; #1;
        check("R10 old low", 32'(status[7]), 0);
        @(negedge clk);

        // Random phase: CTS held, delta clear
        for (int i = 0; i < 400; i++) begin
            rx_count = CNT_W'($urandom_range(DEPTH, 0));
            tx_count = CNT_W'($urandom_range(DEPTH, 0));
            old_data = 1'($urandom);
            enable   = 8'($urandom);
            #1;
            exp_c = {old_data, 1'b0, exp_levels(int'(rx_count), int'(tx_count))};
            check("R1-6 rand status", 32'(status[7:0]), 32'(exp_c));
            exp_irq = |(exp_c & enable);
            @(negedge clk);
            check("R11 rand irq", 32'(irq), 32'(exp_irq));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule